// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital control core of a 12-bit successive-approximation converter. A conversion is requested by a falling edge on an active-low start input, and the request is honoured only while the active-low select input is low at the clock edge that sees the fall. The block then walks a trial code from the top bit to the bottom bit. The trial code goes out to the external DAC. A single comparator bit comes back and says whether the trial value lies above the sampled input. When that bit is set, the bit under test is dropped.

An active-low busy flag marks the conversion. The finished word is copied into an output latch on the same clock edge at which the busy flag returns high. The latch feeds a parallel data port. The port drives only while select and read are both low; otherwise it floats. The analog comparator, the capacitive DAC and the sample-and-hold are outside this block. The bit clock is the ordinary clock input, and a parameter sets how many clock cycles each bit decision takes.

Top module: `sar_conv_seq`

## Requirements
- R1: A conversion starts only when the clock edge samples `startN` low after it was high at the previous edge, and `selN` is low at that same edge. A `startN` fall while `selN` is high, or `startN` held low with no new fall, starts nothing.
- R2: At the start of each conversion the register is cleared and only the top trial bit is set. In the first busy cycle, `trialCode` equals 12'h800.
- R3: Bits are resolved from bit 11 down to bit 0. At each bit's last cycle, a high `cmpHigh` clears the bit under test and the next lower bit is set for trial. With a comparator that reports trial > input, the result is the input code in straight binary: 0 gives 12'h000 and full scale gives 12'hFFF.
- R4: A start request that arrives while a conversion is running neither restarts it nor lengthens it.
- R5: `busyN` goes low on the clock edge that accepts a start and stays low for exactly 12*CYC_PER_BIT+1 cycles.
- R6: The output latch changes only on the edge where `busyN` rises. Throughout a conversion, the port shows the previous result.
- R7: `dataOe` is 1, and `dataBus` drives the latched word, only while `selN` and `readN` are both low. Otherwise `dataOe` is 0 and `dataBus` is high-impedance.
- R8: Reset sets the latch to zero, sets `busyN` high and turns off the port driver.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startN | input | 1 | Active-low start-of-conversion; a falling edge requests a conversion |
| selN | input | 1 | Active-low select; gates start and read |
| readN | input | 1 | Active-low read enable for the data port |
| cmpHigh | input | 1 | Comparator result: 1 when the trial value exceeds the sampled input |
| trialCode | output | 12 | Current trial code sent to the DAC |
| busyN | output | 1 | Low while a conversion runs |
| dataOe | output | 1 | Data port driver enable |
| dataBus | output | 12 | Three-state parallel result port |

## Verification
The hardest case to reach is a second start edge that lands in the middle of a running conversion. The port values cannot show directly whether the sequencer restarted. They only show it through a longer busy window, or through a trial pattern that reaches a wrong result. To create this case, the bench pulses `startN` again several cycles after an accepted start, with select still low. It then checks both the busy length and the final word against a comparator model driven from `trialCode`. A read issued mid-conversion confirms that the latch still holds the previous result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  localparam int DATA_W = 12;
  localparam int IDX_W  = $clog2(DATA_W);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_CONV = 2'd1,
    ST_LOAD = 2'd2
  } seqState_t;

  typedef struct packed {
    logic             startConv;
    logic             resolveBit;
    logic [IDX_W-1:0] bitSel;
    logic             loadOut;
  } seqStrobe_t;
endpackage

// File: rtl/sar_seq_ctrl.sv
module sar_seq_ctrl
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = DATA_W,
  parameter int CYC_PER_BIT = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startN,
  input  logic       selN,
  output seqStrobe_t strb,
  output logic       busyN
);
  localparam int CNT_W = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(CYC_PER_BIT - 1);

  seqState_t        state;
  logic             prevStart;
  logic [IDX_W-1:0] bitIdx;
  logic [CNT_W-1:0] cycCnt;
  logic             startFall;
  logic             accept;
  logic             bitLast;

  assign startFall = prevStart & ~startN;
  assign accept    = (state == ST_IDLE) && startFall && !selN;
  assign bitLast   = (cycCnt == CNT_LAST);

  always_comb begin
    strb.startConv  = accept;
    strb.resolveBit = (state == ST_CONV) && bitLast;
    strb.bitSel     = bitIdx;
    strb.loadOut    = (state == ST_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      prevStart <= 1'b1;
      bitIdx    <= TOP_IDX;
      cycCnt    <= '0;
      busyN     <= 1'b1;
    end else begin
      prevStart <= startN;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state  <= ST_CONV;
            bitIdx <= TOP_IDX;
            cycCnt <= '0;
            busyN  <= 1'b0;
          end
        end
        ST_CONV: begin
          if (bitLast) begin
            cycCnt <= '0;
            if (bitIdx == '0) state <= ST_LOAD;
            else              bitIdx <= bitIdx - 1'b1;
          end else begin
            cycCnt <= cycCnt + 1'b1;
          end
        end
        ST_LOAD: begin
          state <= ST_IDLE;
          busyN <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R1: a conversion only begins if select was low at the accepting edge
  a_r1_start_needs_select: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> !$past(selN));

  // R4: while converting, the bit index never jumps back up (no restart)
  a_r4_no_restart: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_CONV) |=> (state != ST_CONV || bitIdx <= $past(bitIdx)));
endmodule

// File: rtl/sar_seq_dpath.sv
module sar_seq_dpath
  import sar_seq_pkg::*;
#(
  parameter int WIDTH = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  seqStrobe_t       strb,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic [WIDTH-1:0] outLatch
);
  logic [WIDTH-1:0] sarReg;
  logic [WIDTH-1:0] sarNext;

  always_comb begin
    sarNext = sarReg;
    if (cmpHigh) sarNext[strb.bitSel] = 1'b0;
    if (strb.bitSel != '0) sarNext[strb.bitSel - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sarReg   <= '0;
      outLatch <= '0;
    end else begin
      if (strb.startConv)       sarReg <= {1'b1, {(WIDTH-1){1'b0}}};
      else if (strb.resolveBit) sarReg <= sarNext;
      if (strb.loadOut) outLatch <= sarReg;
    end
  end

  assign trialCode = sarReg;
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int WIDTH       = DATA_W,
  parameter int CYC_PER_BIT = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startN,
  input  logic             selN,
  input  logic             readN,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] trialCode,
  output logic             busyN,
  output logic             dataOe,
  output logic [WIDTH-1:0] dataBus
);
  seqStrobe_t       strb;
  logic [WIDTH-1:0] outLatch;

  sar_seq_ctrl #(.WIDTH(WIDTH), .CYC_PER_BIT(CYC_PER_BIT)) u_ctrl (
    .clk(clk), .rstN(rstN), .startN(startN), .selN(selN),
    .strb(strb), .busyN(busyN)
  );

  sar_seq_dpath #(.WIDTH(WIDTH)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpHigh(cmpHigh),
    .trialCode(trialCode), .outLatch(outLatch)
  );

  assign dataOe  = !selN && !readN;
  assign dataBus = dataOe ? outLatch : {WIDTH{1'bz}};

  // R2: first busy cycle shows a cleared register with only the top trial bit
  a_r2_clear_at_start: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busyN) |-> trialCode == {1'b1, {(WIDTH-1){1'b0}}});

  // R6: the output latch moves only together with busy returning high
  a_r6_latch_at_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(outLatch) |-> $rose(busyN));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  localparam int W = 12;
  localparam int BUSY_LEN = 12 * 1 + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startN = 1'b1;
  logic selN = 1'b1;
  logic readN = 1'b1;
  logic cmpHigh;
  logic [W-1:0] trialCode;
  logic busyN;
  logic dataOe;
  logic [W-1:0] dataBus;
  logic [W-1:0] vin = '0;
  logic [W-1:0] lastWord = '0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign cmpHigh = (trialCode > vin);

  sar_conv_seq u_dut (
    .clk(clk), .rstN(rstN), .startN(startN), .selN(selN), .readN(readN),
    .cmpHigh(cmpHigh), .trialCode(trialCode), .busyN(busyN),
    .dataOe(dataOe), .dataBus(dataBus)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] expResult(input logic [W-1:0] v);
    return v;
  endfunction

  task automatic readPort(output logic [W-1:0] word, output logic oe);
    @(negedge clk); selN = 1'b0; readN = 1'b0;
    #1; word = dataBus; oe = dataOe;
    @(negedge clk); readN = 1'b1;
  endtask

  // run one conversion; optional second start mid-way (R4) and mid read (R6)
  task automatic convert(input logic [W-1:0] v, input bit poke, input bit midRead);
    int busyCnt = 0;
    logic [W-1:0] w;
    logic oe;
    vin = v;
    @(negedge clk); selN = 1'b0; startN = 1'b0;
    @(negedge clk);
    check("R2 trial at start", trialCode, 12'h800);
    startN = 1'b1;
    while (busyN == 1'b0 && busyCnt < 200) begin
      busyCnt++;
      if (poke && busyCnt == 4) startN = 1'b0;
      if (poke && busyCnt == 5) startN = 1'b1;
      if (midRead && busyCnt == 6) begin
        readN = 1'b0; #1;
        check("R6 latch holds old word", dataBus, lastWord);
        readN = 1'b1;
      end
      @(negedge clk);
    end
    if (poke) check("R4 busy length with extra start", busyCnt, BUSY_LEN);
    else      check("R5 busy length", busyCnt, BUSY_LEN);
    readPort(w, oe);
    check("R7 oe during read", oe, 1'b1);
    check("R3 result", w, expResult(v));
    lastWord = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] w;
    logic oe;
    void'($urandom(32'd1415));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R8 busy idle after reset", busyN, 1'b1);
    check("R8 port off after reset", dataOe, 1'b0);
    readPort(w, oe);
    check("R8 latch zero after reset", w, 12'h000);

    convert(12'h000, 0, 0);
    convert(12'hFFF, 0, 1);
    convert(12'h800, 0, 1);
    convert(12'h7FF, 0, 0);
    convert(12'h001, 1, 1);
    convert(12'hA5A, 1, 0);

    // R1: falling start while deselected is ignored
    vin = 12'h123;
    @(negedge clk); selN = 1'b1; startN = 1'b0;
    @(negedge clk); selN = 1'b0;
    repeat (20) begin
      @(negedge clk);
      if (busyN !== 1'b1) break;
    end
    check("R1 deselected fall ignored", busyN, 1'b1);
    startN = 1'b1;
    readPort(w, oe);
    check("R1 latch unchanged", w, lastWord);

    // R1: start held low with no new fall does nothing
    @(negedge clk); selN = 1'b1; startN = 1'b0;
    @(negedge clk); selN = 1'b0;
    repeat (10) @(negedge clk);
    check("R1 level low no fall", busyN, 1'b1);
    startN = 1'b1;

    // R7: port off unless both select and read low
    @(negedge clk); selN = 1'b0; readN = 1'b1; #1;
    check("R7 read high off", dataOe, 1'b0);
    @(negedge clk); selN = 1'b1; readN = 1'b0; #1;
    check("R7 select high off", dataOe, 1'b0);
    @(negedge clk); readN = 1'b1;

    for (int i = 0; i < 24; i++) begin
      logic [W-1:0] rv;
      rv = W'($urandom_range(0, 4095));
      convert(rv, ($urandom_range(0, 3) == 0), ($urandom_range(0, 1) == 1));
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule